// File: doc/BRIEF.md
# Dual-Direction Composite-Field Byte Substitution Unit

This block performs the byte substitution step of the AES cipher in either direction, with no lookup table. The byte is treated as an element of GF(2^8). It is moved by a linear isomorphism into a tower field GF(((2^2)^2)^2), inverted with small subfield circuits, and moved back. The affine transform is applied after the inversion for encryption. Its inverse is applied before the inversion for decryption. One mapping, inversion and unmapping datapath serves both directions.

The tower constants and both basis-change matrices are derived at elaboration from the field definitions, so they always match each other. A parameter selects either a purely combinational path or a single output register with asynchronous reset. The unit is meant to be replicated sixteen times in a round datapath, or four times in a column-wide one.

Top module: `aes_cf_sbox`

## Requirements
- R1: With `fwd`=1, `dout` equals the forward S-box of `din`. The forward S-box is the multiplicative inverse in GF(2^8) modulo x^8+x^4+x^3+x+1 (0x11B), with zero mapped to zero. That inverse then passes through the affine transform: output bit i = b[i]^b[i+4]^b[i+5]^b[i+6]^b[i+7] (indices mod 8) XOR bit i of 0x63. This holds for all 256 inputs.
- R2: With `fwd`=0, `dout` equals the inverse S-box of `din`. The inverse S-box takes the inverse affine transform (bit i = b[i+2]^b[i+5]^b[i+7] mod 8, XOR 0x05) and then the GF(2^8) inverse. This holds for all 256 inputs.
- R3: Input 0x00 in the forward direction gives 0x63.
- R4: Input 0x63 in the inverse direction gives 0x00.
- R5: For every byte x, the inverse result of the forward result of x is x.
- R6: No input is mapped to itself, in either direction.
- R7: With REG_OUT=1, `dout` is 0x00 while `rst_n` is low. The result for inputs present before a rising clock edge appears after that edge. With REG_OUT=0, `dout` follows the inputs in the same cycle.
- R8: When `fwd` and `din` both change in the same cycle, the output is correct for the new pair and carries nothing over from the previous direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register and for the checks |
| rst_n | input | 1 | Active-low asynchronous reset |
| fwd | input | 1 | 1 selects the forward S-box, 0 selects the inverse S-box |
| din | input | 8 | Byte to substitute |
| dout | output | 8 | Substituted byte |

## Verification
The forward and inverse substitutions share one inversion datapath, and the direction mux sits on both sides of it. A direction change and a data change can therefore arrive in the same cycle. The bench provokes this by toggling `fwd` on every cycle while it walks through bytes. It judges each output against a reference built from GF(2^8) exponentiation, and it repeats the sweep on a registered instance. Both directions are also swept exhaustively, and the round trip is checked.

// File: rtl/aes_cf_sbox.sv
module aes_cf_sbox #(
  parameter bit REG_OUT = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fwd,
  input  logic [7:0] din,
  output logic [7:0] dout
);

  function automatic logic [1:0] g4mul(input logic [1:0] a, input logic [1:0] b);
    return {(a[1] & b[1]) ^ (a[1] & b[0]) ^ (a[0] & b[1]),
            (a[1] & b[1]) ^ (a[0] & b[0])};
  endfunction

  function automatic logic [1:0] g4sq(input logic [1:0] a);
    return {a[1], a[1] ^ a[0]};
  endfunction

  function automatic logic [3:0] g16mul(input logic [3:0] a, input logic [3:0] b);
    logic [1:0] hh;
    hh = g4mul(a[3:2], b[3:2]);
    return {hh ^ g4mul(a[3:2], b[1:0]) ^ g4mul(a[1:0], b[3:2]),
            g4mul(hh, 2'b10) ^ g4mul(a[1:0], b[1:0])};
  endfunction

  function automatic logic [3:0] g16inv(input logic [3:0] a);
    logic [1:0] d, di;
    d  = g4mul(g4sq(a[3:2]), 2'b10) ^ g4mul(a[1:0], a[3:2] ^ a[1:0]);
    di = g4sq(d);
    return {g4mul(a[3:2], di), g4mul(a[3:2] ^ a[1:0], di)};
  endfunction

  function automatic logic [7:0] g256mul(input logic [7:0] a, input logic [7:0] b,
                                         input logic [3:0] lam);
    logic [3:0] hh;
    hh = g16mul(a[7:4], b[7:4]);
    return {hh ^ g16mul(a[7:4], b[3:0]) ^ g16mul(a[3:0], b[7:4]),
            g16mul(hh, lam) ^ g16mul(a[3:0], b[3:0])};
  endfunction

  function automatic logic [7:0] g256inv(input logic [7:0] a, input logic [3:0] lam);
    logic [3:0] d, di;
    d  = g16mul(g16mul(a[7:4], a[7:4]), lam) ^ g16mul(a[3:0], a[7:4] ^ a[3:0]);
    di = g16inv(d);
    return {g16mul(a[7:4], di), g16mul(a[7:4] ^ a[3:0], di)};
  endfunction

  function automatic logic [7:0] apply_mat(input logic [63:0] m, input logic [7:0] x);
    logic [7:0] r;
    r = '0;
    for (int i = 0; i < 8; i++)
      if (x[i]) r = r ^ m[8*i +: 8];
    return r;
  endfunction

  function automatic logic [3:0] find_lam();
    logic [3:0] best;
    logic hit, done;
    best = 4'h0;
    done = 1'b0;
    for (int l = 1; l < 16; l++) begin
      hit = 1'b0;
      for (int z = 0; z < 16; z++)
        if ((g16mul(4'(z), 4'(z)) ^ 4'(z)) == 4'(l)) hit = 1'b1;
      if (!hit && !done) begin
        best = 4'(l);
        done = 1'b1;
      end
    end
    return best;
  endfunction

  localparam logic [3:0] LAM = find_lam();

  function automatic logic [63:0] find_map();
    logic [7:0] b1, b2, b3, b4, b8, p, beta, pw;
    logic [63:0] m;
    logic done;
    beta = 8'h00;
    done = 1'b0;
    for (int c = 2; c < 256; c++) begin
      b1 = 8'(c);
      b2 = g256mul(b1, b1, LAM);
      b3 = g256mul(b2, b1, LAM);
      b4 = g256mul(b2, b2, LAM);
      b8 = g256mul(b4, b4, LAM);
      p  = b8 ^ b4 ^ b3 ^ b1 ^ 8'h01;
      if (p == 8'h00 && !done) begin
        beta = b1;
        done = 1'b1;
      end
    end
    pw = 8'h01;
    m  = '0;
    for (int i = 0; i < 8; i++) begin
      m[8*i +: 8] = pw;
      pw = g256mul(pw, beta, LAM);
    end
    return m;
  endfunction

  localparam logic [63:0] MAPV = find_map();

  function automatic logic [63:0] find_unmap();
    logic [63:0] m;
    m = '0;
    for (int j = 0; j < 8; j++)
      for (int a = 0; a < 256; a++)
        if (apply_mat(MAPV, 8'(a)) == (8'h01 << j)) m[8*j +: 8] = 8'(a);
    return m;
  endfunction

  localparam logic [63:0] UNMAPV = find_unmap();

  function automatic logic [7:0] aff_fwd(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      r[i] = b[i] ^ b[(i+4)%8] ^ b[(i+5)%8] ^ b[(i+6)%8] ^ b[(i+7)%8];
    return r ^ 8'h63;
  endfunction

  function automatic logic [7:0] aff_inv(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      r[i] = b[(i+2)%8] ^ b[(i+5)%8] ^ b[(i+7)%8];
    return r ^ 8'h05;
  endfunction

  logic [7:0] pre, twr, twr_inv, post, res;

  assign pre     = fwd ? din : aff_inv(din);
  assign twr     = apply_mat(MAPV, pre);
  assign twr_inv = g256inv(twr, LAM);
  assign post    = apply_mat(UNMAPV, twr_inv);
  assign res     = fwd ? aff_fwd(post) : post;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) dout <= 8'h00;
        else        dout <= res;
    end else begin : g_comb
      assign dout = res;
    end
  endgenerate

  // tower inversion must yield a true inverse for every nonzero element
  assert_field_inverse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (twr != 8'h00) |-> (g256mul(twr, twr_inv, LAM) == 8'h01));

  assert_zero_forward_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd && din == 8'h00) |-> (res == 8'h63));

  assert_inverse_of_63_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwd && din == 8'h63) |-> (res == 8'h00));

  assert_no_fixed_point_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res != din);

endmodule

// File: tb/aes_cf_sbox_test.sv
`timescale 1ns/1ps
module aes_cf_sbox_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fwd = 1'b1;
  logic [7:0] din = 8'h00;
  logic [7:0] dout, dout_r;
  int checks = 0;
  int errors = 0;
  logic [7:0] fref [256];
  logic [7:0] iref [256];

  always #2.5 clk = ~clk;

  aes_cf_sbox #(.REG_OUT(1'b0)) uut (.clk(clk), .rst_n(rst_n), .fwd(fwd), .din(din), .dout(dout));
  aes_cf_sbox #(.REG_OUT(1'b1)) uut_reg (.clk(clk), .rst_n(rst_n), .fwd(fwd), .din(din), .dout(dout_r));

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r, x;
    r = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ x;
      x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl(input logic [7:0] v, input int n);
    return 8'((v << n) | (v >> (8 - n)));
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic build_ref();
    logic [7:0] p, inv;
    for (int a = 0; a < 256; a++) begin
      p = 8'h01;
      for (int k = 0; k < 254; k++) p = gmul(p, 8'(a));
      inv = (a == 0) ? 8'h00 : p;
      fref[a] = inv ^ rotl(inv,1) ^ rotl(inv,2) ^ rotl(inv,3) ^ rotl(inv,4) ^ 8'h63;
    end
    for (int a = 0; a < 256; a++) iref[fref[a]] = 8'(a);
  endtask

  task automatic apply(input logic f, input logic [7:0] d);
    @(negedge clk);
    fwd = f;
    din = d;
    #1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R7 reset", dout_r, 8'h00);
  endtask

  task automatic t_forward_sweep();
    for (int a = 0; a < 256; a++) begin
      apply(1'b1, 8'(a));
      check("R1 forward", dout, fref[a]);
    end
    apply(1'b1, 8'h00);
    check("R3 zero forward", dout, 8'h63);
  endtask

  task automatic t_inverse_sweep();
    for (int a = 0; a < 256; a++) begin
      apply(1'b0, 8'(a));
      check("R2 inverse", dout, iref[a]);
    end
    apply(1'b0, 8'h63);
    check("R4 inverse of 63", dout, 8'h00);
  endtask

  task automatic t_round_trip();
    logic [7:0] mid;
    for (int a = 0; a < 256; a += 7) begin
      apply(1'b1, 8'(a));
      mid = dout;
      if (mid == 8'(a)) check("R6 forward fixed point", mid, ~mid);
      apply(1'b0, mid);
      check("R5 round trip", dout, 8'(a));
      if (dout == mid) check("R6 inverse fixed point", dout, ~dout);
    end
  endtask

  task automatic t_alternate();
    for (int a = 0; a < 64; a++) begin
      apply(a[0], 8'(a * 37 + 5));
      check("R8 toggle", dout, a[0] ? fref[8'(a * 37 + 5)] : iref[8'(a * 37 + 5)]);
    end
  endtask

  task automatic t_registered();
    for (int a = 0; a < 32; a++) begin
      apply(a[1], 8'(a * 11 + 3));
      @(posedge clk);
      #1;
      check("R7 registered", dout_r, a[1] ? fref[8'(a * 11 + 3)] : iref[8'(a * 11 + 3)]);
    end
  endtask

  initial begin
    build_ref();
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_forward_sweep();
    t_inverse_sweep();
    t_round_trip();
    t_alternate();
    t_registered();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule